// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances on a clock-enable running at instruction rate. A selectable prescaler sits in front of the counter and divides the enable by 1, 4 or 16. On each advance the counter is compared with a period register. When the two are equal, the counter returns to zero instead of incrementing. The same event also produces a one-cycle match pulse for downstream PWM or serial-clock logic.

Each match event is also counted by a 4-bit postscaler. Every (N+1)th match sets a sticky interrupt flag. Software reaches the block through a simple register port with four addresses: the counter value, the period value, the control register and the flag. A hold input keeps the whole block in its reset state while the module is disabled.

Register map: address 0 is the counter, 1 the period, 2 the control, 3 the flag (bit 0). The control register has these fields:
- bit 0: enable.
- bits 2:1: prescale select. 0 gives 1:1, 1 gives 1:4, 2 and 3 give 1:16.
- bits 6:3: postscale value N.
- bit 7: reads as 0.

Top module: `pm_timer`

## Requirements
- R1: After reset the counter reads 00h, the period reads FFh, the control reads 00h, the flag reads 0, and `match_o` and `irq_o` are low.
- R2: With enable set, the counter advances on a `tick_i` cycle only at the prescaler terminal count. Prescale select 0 advances on every tick, select 1 on every 4th tick, and selects 2 and 3 on every 16th tick. Cycles without `tick_i` change nothing.
- R3: An advance that finds counter == period loads 00h instead of incrementing. In the following clock cycle `match_o` is high for one cycle, while the counter reads 00h. The counter therefore cycles through period+1 values.
- R4: With postscale value N (control bits 6:3), the flag is set on every (N+1)th match, counted from the last scaler clear.
- R5: The flag stays set until a write to address 3 with data bit 0 = 0. A write with bit 0 = 1 has no effect. If a flag set and a clear write fall in the same cycle, the flag ends up set.
- R6: A write to the counter loads the written value and clears both the prescaler and the postscaler. No advance happens in that cycle.
- R7: A write to the control register clears both scaler counters but leaves the counter value unchanged.
- R8: While `hold_i` is high, every register returns to its reset value and writes are ignored.
- R9: With enable clear, the counter holds its value, no match occurs and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Module disable: hold in reset |
| tick_i | input | 1 | Instruction-rate count enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 counter, 1 period, 2 control, 3 flag) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address, same map |
| rd_data_o | output | 8 | Read data (combinational) |
| match_o | output | 1 | Unscaled period-match pulse |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench sweeps every prescale select against periods 0, 2 and 7 and postscale values 0, 3 and 15. For each combination it measures the exact number of cycles from the counter write to the flag, and counts the match pulses seen along the way. An off-by-one in the wrap (resetting at period instead of period+1) or in the postscale decode (dividing by N instead of N+1) shows up there as a wrong cycle count.

The bench also writes the counter and the control register in the middle of a prescale interval. A design that forgets to clear the prescaler advances early, and one that clears the counter on a control write loses its value. Finally, a flag clear is timed to land on the same edge as a flag set. A design that gives the clear priority drops that interrupt.

// File: rtl/pm_timer_pkg.sv
package pm_timer_pkg;
  localparam int PRE_SEL_W = 2;
  localparam int POST_W    = 4;
  localparam int ADDR_W    = 2;
  localparam int CTL_W     = POST_W + PRE_SEL_W + 1;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TMR = 2'd0,
    ADDR_PRD = 2'd1,
    ADDR_CTL = 2'd2,
    ADDR_FLG = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [POST_W-1:0]    post;
    logic [PRE_SEL_W-1:0] pre;
    logic                 on;
  } ctl_t;
endpackage

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
  parameter int NUM_OPT = 3,
  parameter int SEL_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cnt_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tc_o
);
  localparam int CNT_W = 2 * (NUM_OPT - 1);
  localparam int SLOTS = 2 ** SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [SLOTS-1:0] tc_slot;

  // option k divides by 4**k; selects beyond the last option reuse it
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam int K = (k < NUM_OPT) ? k : NUM_OPT - 1;
    if (K == 0) begin : g_direct
      assign tc_slot[k] = 1'b1;
    end else begin : g_div
      assign tc_slot[k] = &cnt_q[2*K-1:0];
    end
  end

  assign tc_o = cnt_en_i & tc_slot[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (cnt_en_i) cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/pm_postscaler.sv
module pm_postscaler #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] sel_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign fire_o = hit_i & (cnt_q == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (fire_o)  cnt_q <= '0;
    else if (hit_i)   cnt_q <= cnt_q + 1'b1;
  end

  AST_POST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= sel_i); // R4
endmodule

// File: rtl/pm_timer.sv
module pm_timer
  import pm_timer_pkg::*;
#(
  parameter int TMR_W   = 8,
  parameter int NUM_OPT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [TMR_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [TMR_W-1:0]  rd_data_o,
  output logic              match_o,
  output logic              irq_o
);
  localparam int CTL_PAD = TMR_W - CTL_W;

  logic [TMR_W-1:0] tmr_q, prd_q;
  ctl_t             ctl_q;
  logic             flag_q, match_q;
  logic             wr_ok, tmr_wr, prd_wr, ctl_wr, flg_clr;
  logic             scaler_clr, cnt_en, adv, hit, fire;
  logic [CTL_W-1:0] ctl_bits;

  assign wr_ok      = wr_en_i & ~hold_i;
  assign tmr_wr     = wr_ok & (wr_addr_i == ADDR_TMR);
  assign prd_wr     = wr_ok & (wr_addr_i == ADDR_PRD);
  assign ctl_wr     = wr_ok & (wr_addr_i == ADDR_CTL);
  assign flg_clr    = wr_ok & (wr_addr_i == ADDR_FLG) & ~wr_data_i[0];
  assign scaler_clr = hold_i | tmr_wr | ctl_wr;
  assign cnt_en     = ctl_q.on & tick_i & ~scaler_clr;
  assign hit        = adv & (tmr_q == prd_q);

  pm_prescaler #(.NUM_OPT(NUM_OPT), .SEL_W(PRE_SEL_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (scaler_clr),
    .cnt_en_i (cnt_en),
    .sel_i    (ctl_q.pre),
    .tc_o     (adv)
  );

  pm_postscaler #(.CNT_W(POST_W)) u_post (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (scaler_clr),
    .hit_i  (hit),
    .sel_i  (ctl_q.post),
    .fire_o (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q   <= '0;
      prd_q   <= '1;
      ctl_q   <= '0;
      flag_q  <= 1'b0;
      match_q <= 1'b0;
    end else if (hold_i) begin
      tmr_q   <= '0;
      prd_q   <= '1;
      ctl_q   <= '0;
      flag_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= hit;
      if (tmr_wr)   tmr_q <= wr_data_i;
      else if (hit) tmr_q <= '0;
      else if (adv) tmr_q <= tmr_q + 1'b1;
      if (prd_wr) prd_q <= wr_data_i;
      if (ctl_wr) ctl_q <= wr_data_i[CTL_W-1:0];
      if (fire)         flag_q <= 1'b1;  // set beats clear
      else if (flg_clr) flag_q <= 1'b0;
    end
  end

  assign ctl_bits = ctl_q;

  always_comb begin
    unique case (rd_addr_i)
      ADDR_TMR: rd_data_o = tmr_q;
      ADDR_PRD: rd_data_o = prd_q;
      ADDR_CTL: rd_data_o = {{CTL_PAD{1'b0}}, ctl_bits};
      default:  rd_data_o = {{(TMR_W-1){1'b0}}, flag_q};
    endcase
  end

  assign match_o = match_q;
  assign irq_o   = flag_q;

  AST_OFF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q.on && !wr_en_i && !hold_i) |=> (tmr_q == $past(tmr_q))); // R9
  AST_MATCH_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> (tmr_q == '0)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !hold_i && !flg_clr) |=> flag_q); // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !hold_i) |=> flag_q); // R5
  AST_CTL_KEEPS_TMR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> (tmr_q == $past(tmr_q))); // R7
  AST_HOLD_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (tmr_q == '0 && prd_q == '1 && !flag_q && !match_q)); // R8
endmodule

// File: tb/tb_pm_timer.sv
`timescale 1ns/1ps
module tb_pm_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold = 1'b0;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       match, irq;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pm_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .hold_i(hold), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .match_o(match), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic logic [7:0] ctl(input int post, input int sel, input bit on);
    return {1'b0, post[3:0], sel[1:0], on};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int v, n, m, divs;
    int prds[3] = '{0, 2, 7};
    int posts[3] = '{0, 3, 15};
    step(2);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 tmr", v, 8'h00);
    rd(1, v); chk("R1 prd", v, 8'hFF);
    rd(2, v); chk("R1 ctl", v, 8'h00);
    rd(3, v); chk("R1 flag", v, 0);
    chk("R1 match", match, 0);
    chk("R1 irq", irq, 0);

    // R2/R3/R4 sweep: cycles to flag = (prd+1)*div*(N+1)
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 3; p++) begin
        for (int q = 0; q < 3; q++) begin
          divs = (s == 0) ? 1 : (s == 1) ? 4 : 16;
          wr(2, ctl(0, 0, 0));
          wr(3, 8'h00);
          wr(1, prds[p][7:0]);
          wr(2, ctl(posts[q], s, 1));
          wr(0, 8'h00);
          n = 0; m = 0;
          while (!irq && n < 5000) begin
            step(1); n++;
            if (match) m++;
          end
          chk($sformatf("R2 R4 cycles s=%0d p=%0d N=%0d", s, prds[p], posts[q]),
              n, (prds[p] + 1) * divs * (posts[q] + 1));
          chk($sformatf("R3 match count s=%0d p=%0d N=%0d", s, prds[p], posts[q]),
              m, posts[q] + 1);
        end
      end
    end

    // R3 wrap sequence, period 2, 1:1
    wr(2, ctl(0, 0, 0)); wr(3, 8'h00); wr(1, 8'd2);
    wr(2, ctl(15, 0, 1)); wr(0, 8'h00);
    step(1); rd(0, v); chk("R3 seq1", v, 1); chk("R3 nomatch1", match, 0);
    step(1); rd(0, v); chk("R3 seq2", v, 2); chk("R3 nomatch2", match, 0);
    step(1); rd(0, v); chk("R3 wrap", v, 0); chk("R3 match", match, 1);
    step(1); rd(0, v); chk("R3 after", v, 1); chk("R3 pulse width", match, 0);

    // R2 no tick => no advance
    tick = 1'b0; step(10); rd(0, v); chk("R2 no tick", v, 1);
    tick = 1'b1;

    // R6 counter write clears prescaler (1:4)
    wr(1, 8'hFF); wr(2, ctl(0, 1, 1)); wr(0, 8'h00);
    step(2);
    wr(0, 8'h40);
    step(3); rd(0, v); chk("R6 no early adv", v, 8'h40);
    step(1); rd(0, v); chk("R6 adv on 4th", v, 8'h41);

    // R7 control write clears prescaler, keeps counter
    wr(0, 8'h00); step(2);
    wr(2, ctl(0, 1, 1));
    step(3); rd(0, v); chk("R7 no early adv", v, 0);
    step(1); rd(0, v); chk("R7 adv on 4th", v, 1);
    wr(2, ctl(0, 0, 1)); wr(0, 8'h10); step(5);
    wr(2, ctl(0, 0, 0));
    rd(0, v); chk("R7 counter kept", v, 8'h15);

    // R9 disabled: frozen, no flag
    wr(3, 8'h00); wr(0, 8'h12); m = 0;
    for (int i = 0; i < 50; i++) begin step(1); if (match) m++; end
    rd(0, v); chk("R9 frozen", v, 8'h12);
    chk("R9 no match", m, 0);
    chk("R9 no flag", irq, 0);

    // R5 sticky flag, write-1 ignored, set beats clear
    wr(1, 8'd3); wr(2, ctl(0, 0, 1)); wr(0, 8'h00);
    step(4); chk("R5 set", irq, 1);
    wr(2, ctl(0, 0, 0));
    wr(3, 8'h01); rd(3, v); chk("R5 write 1 ignored", v, 1);
    step(5); chk("R5 sticky", irq, 1);
    wr(2, ctl(0, 0, 1)); wr(0, 8'h00);
    step(3);
    wr(3, 8'h00); // lands on the setting edge
    chk("R5 set wins", irq, 1);
    wr(2, ctl(0, 0, 0));
    wr(3, 8'h00); chk("R5 cleared", irq, 0);

    // R8 hold forces reset, ignores writes
    wr(1, 8'h55); wr(2, ctl(2, 1, 1));
    hold = 1'b1;
    wr(1, 8'h33); wr(0, 8'h77);
    rd(1, v); chk("R8 prd", v, 8'hFF);
    rd(0, v); chk("R8 tmr", v, 0);
    rd(2, v); chk("R8 ctl", v, 0);
    chk("R8 irq", irq, 0);
    hold = 1'b0;
    step(20); rd(0, v); chk("R8 stays off", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule